// File: doc/BRIEF.md
# Reorder Buffer With Precise Exceptions

This block keeps instructions in program order between dispatch and architectural completion. Dispatch presents one instruction at a time with its PC. The block places it in the next free slot of a circular queue and returns that slot number as the instruction's tag. Execution units later report finish events in any order. Each event names a tag and carries a result value, a destination register number and an exception flag.

Each cycle the block looks at the oldest entries and writes their results to the architectural register file through up to two commit lanes, strictly oldest first. An entry that finished with its exception flag set is never committed. Entries older than it drain normally. Once it reaches the head, the block raises a one-cycle flush pulse and drives the faulting instruction's PC as the restart address. In the same cycle it discards every entry still held, including entries that already finished. Fetch restarts from that PC.

The dispatch port follows valid/ready rules. A transfer happens on a cycle where both `disp_valid` and `disp_ready` are high. `disp_valid` may stay high across cycles where `disp_ready` is low, and nothing is taken in those cycles. The finish port and the commit lanes apply no back-pressure: a finish event is taken in the cycle it is presented, and a commit lane is consumed in the cycle it is driven.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `ret_en` is 0, `flush` is 0 and `disp_tag` is 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. The tag it receives equals `disp_tag` in that cycle. Successive accepted dispatches receive consecutive slot numbers, and the number after DEPTH-1 is 0.
- R3: When DEPTH entries are in flight, `disp_ready` is 0. A `disp_valid` held high in that state allocates nothing and leaves `disp_tag` unchanged.
- R4: A finish event (`fin_valid` high) marks the entry named by `fin_tag` as finished and stores its `fin_data`, `fin_dest` and `fin_exc`. Events may arrive in any order.
- R5: Entries commit only from the head, in program order. An unfinished entry blocks every younger entry, even younger entries that have finished. A commit drives the entry's stored destination and result on its lane.
- R6: Up to two entries commit per cycle. Lane 0 (bit 0 of `ret_en`, low slice of `ret_dest`/`ret_data`) always carries the older entry, and lane 1 is active only when lane 0 is.
- R7: Commit stops at an entry that finished with its exception flag set. Older finished entries still commit, and the excepting entry's result is never written.
- R8: When the head entry has finished with its exception flag set, `flush` is high for exactly one cycle and `restart_pc` equals that entry's dispatch PC. In that cycle no lane commits and `disp_ready` is 0. All held entries are discarded, and no discarded entry ever commits.
- R9: In the cycle after a flush the buffer is empty and `disp_tag` equals the slot number of the excepting entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_tag | output | IDX_W | Slot the next accepted dispatch receives |
| fin_valid | input | 1 | Finish event present |
| fin_tag | input | IDX_W | Slot of the finishing instruction |
| fin_exc | input | 1 | Finishing instruction raised an exception |
| fin_dest | input | DEST_W | Destination register number |
| fin_data | input | DATA_W | Result value |
| ret_en | output | NRET | Per-lane commit strobe |
| ret_dest | output | NRET*DEST_W | Per-lane destination register |
| ret_data | output | NRET*DATA_W | Per-lane result value |
| flush | output | 1 | One-cycle flush pulse |
| restart_pc | output | PC_W | Fetch restart address, valid with `flush` |

## Verification
A head pointer that slips shows up at the commit lanes in the same cycle, either as a result paired with the wrong destination or as a commit that breaks program order. The scoreboard catches this on the first mismatched pop. A tail pointer or occupancy error shows up as a wrong `disp_tag` on the next dispatch, or as `disp_ready` being wrong at the full boundary. A stale finished bit, or a flush that fails to clear the buffer, leads to a discarded result being committed within a cycle or two of the restart. The scoreboard flags this because its queue is already empty at that point.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned DEF_DEPTH  = 40;
  localparam int unsigned DEF_NRET   = 2;
  localparam int unsigned DEF_PC_W   = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_DEST_W = 5;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned NRET  = 2,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             flush,
  input  logic [NRET-1:0]  ret_en,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   occ
);
  localparam int unsigned PW = IDX_W + 1;

  // pointer = {wrap bit, slot index}
  logic [PW-1:0] h_ptr, t_ptr, h_next;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p[IDX_W-1:0] == IDX_W'(DEPTH - 1))
      return {~p[IDX_W], {IDX_W{1'b0}}};
    else
      return p + PW'(1);
  endfunction

  always_comb begin
    h_next = h_ptr;
    for (int k = 0; k < int'(NRET); k++)
      if (ret_en[k]) h_next = bump(h_next);
  end

  assign head_idx = h_ptr[IDX_W-1:0];
  assign tail_idx = t_ptr[IDX_W-1:0];
  assign occ = (h_ptr[IDX_W] == t_ptr[IDX_W])
             ? ({1'b0, t_ptr[IDX_W-1:0]} - {1'b0, h_ptr[IDX_W-1:0]})
             : (PW'(DEPTH) - {1'b0, h_ptr[IDX_W-1:0]} + {1'b0, t_ptr[IDX_W-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ptr <= '0;
      t_ptr <= '0;
    end else begin
      h_ptr <= h_next;
      if (flush)      t_ptr <= h_ptr;
      else if (alloc) t_ptr <= bump(t_ptr);
    end
  end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned NRET   = 2,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEST_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc,
  input  logic [IDX_W-1:0]       alloc_idx,
  input  logic [PC_W-1:0]        alloc_pc,
  input  logic                   fin_en,
  input  logic [IDX_W-1:0]       fin_idx,
  input  logic                   fin_exc,
  input  logic [DEST_W-1:0]      fin_dest,
  input  logic [DATA_W-1:0]      fin_data,
  input  logic [NRET*IDX_W-1:0]  rd_idx,
  output logic [NRET-1:0]        rd_done,
  output logic [NRET-1:0]        rd_exc,
  output logic [NRET*DEST_W-1:0] rd_dest,
  output logic [NRET*DATA_W-1:0] rd_data,
  output logic [PC_W-1:0]        rd_pc
);
  logic [DEPTH-1:0]  done_q, exc_q;
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  // status bits: cleared on allocation, set by the finish event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      if (alloc) begin
        done_q[alloc_idx] <= 1'b0;
        exc_q[alloc_idx]  <= 1'b0;
      end
      if (fin_en) begin
        done_q[fin_idx] <= 1'b1;
        exc_q[fin_idx]  <= fin_exc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) pc_q[alloc_idx] <= alloc_pc;
    if (fin_en) begin
      dest_q[fin_idx] <= fin_dest;
      data_q[fin_idx] <= fin_data;
    end
  end

  for (genvar k = 0; k < int'(NRET); k++) begin : g_rd
    logic [IDX_W-1:0] ix;
    assign ix = rd_idx[k*IDX_W +: IDX_W];
    assign rd_done[k] = done_q[ix];
    assign rd_exc[k]  = exc_q[ix];
    assign rd_dest[k*DEST_W +: DEST_W] = dest_q[ix];
    assign rd_data[k*DATA_W +: DATA_W] = data_q[ix];
  end

  assign rd_pc = pc_q[rd_idx[IDX_W-1:0]];
endmodule

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int unsigned NRET  = 2,
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W:0]   occ,
  input  logic [NRET-1:0]  done,
  input  logic [NRET-1:0]  exc,
  output logic [NRET-1:0]  ret_en,
  output logic             flush
);
  logic go;

  // commit chain stops at the first lane that is empty, unfinished or faulting
  always_comb begin
    go = 1'b1;
    for (int k = 0; k < int'(NRET); k++) begin
      ret_en[k] = go && (occ > (IDX_W+1)'(k)) && done[k] && !exc[k];
      go = ret_en[k];
    end
  end

  assign flush = (occ != '0) && done[0] && exc[0];
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned NRET   = DEF_NRET,
  parameter int unsigned PC_W   = DEF_PC_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEST_W = DEF_DEST_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [PC_W-1:0]        disp_pc,
  output logic [IDX_W-1:0]       disp_tag,
  input  logic                   fin_valid,
  input  logic [IDX_W-1:0]       fin_tag,
  input  logic                   fin_exc,
  input  logic [DEST_W-1:0]      fin_dest,
  input  logic [DATA_W-1:0]      fin_data,
  output logic [NRET-1:0]        ret_en,
  output logic [NRET*DEST_W-1:0] ret_dest,
  output logic [NRET*DATA_W-1:0] ret_data,
  output logic                   flush,
  output logic [PC_W-1:0]        restart_pc
);
  localparam int unsigned OCC_W = IDX_W + 1;

  logic [IDX_W-1:0]      head_idx, tail_idx;
  logic [OCC_W-1:0]      occ;
  logic                  alloc;
  logic [NRET*IDX_W-1:0] lane_idx;
  logic [NRET-1:0]       lane_done, lane_exc;

  assign disp_ready = (occ != OCC_W'(DEPTH)) && !flush;
  assign alloc      = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  // lane k looks at slot head+k, wrapped at DEPTH
  for (genvar k = 0; k < int'(NRET); k++) begin : g_lane
    logic [OCC_W-1:0] sum;
    assign sum = {1'b0, head_idx} + OCC_W'(k);
    assign lane_idx[k*IDX_W +: IDX_W] = (sum >= OCC_W'(DEPTH))
                                      ? IDX_W'(sum - OCC_W'(DEPTH))
                                      : sum[IDX_W-1:0];
  end

  rob_ptrs #(.DEPTH(DEPTH), .NRET(NRET), .IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .flush(flush),
    .ret_en(ret_en), .head_idx(head_idx), .tail_idx(tail_idx), .occ(occ)
  );

  rob_store #(.DEPTH(DEPTH), .NRET(NRET), .IDX_W(IDX_W), .PC_W(PC_W),
              .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .alloc_idx(tail_idx), .alloc_pc(disp_pc),
    .fin_en(fin_valid), .fin_idx(fin_tag), .fin_exc(fin_exc),
    .fin_dest(fin_dest), .fin_data(fin_data),
    .rd_idx(lane_idx), .rd_done(lane_done), .rd_exc(lane_exc),
    .rd_dest(ret_dest), .rd_data(ret_data), .rd_pc(restart_pc)
  );

  rob_commit #(.NRET(NRET), .IDX_W(IDX_W)) u_commit (
    .occ(occ), .done(lane_done), .exc(lane_exc),
    .ret_en(ret_en), .flush(flush)
  );
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned NRET  = 2,
  parameter int unsigned IDX_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [NRET-1:0] ret_en,
  input logic            flush,
  input logic [IDX_W:0]  occ
);
  // R3
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (IDX_W+1)'(DEPTH)) |-> !disp_ready);

  // R3
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IDX_W+1)'(DEPTH));

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && ret_en == '0) |=> (occ == $past(occ) + 1'b1));

  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_en == '0 && !disp_ready));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  for (genvar k = 1; k < int'(NRET); k++) begin : g_ord
    // R6
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en[k] |-> ret_en[k-1]);
  end
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .NRET(NRET), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .ret_en(ret_en), .flush(flush), .occ(occ)
);

// File: tb/tb_reorder_buf.sv
module tb_reorder_buf;
  localparam int DEPTH = 40, NRET = 2, IDX_W = 6;
  localparam int PC_W = 32, DATA_W = 32, DEST_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   rst_n, disp_valid, disp_ready, fin_valid, fin_exc, flush;
  logic [PC_W-1:0]        disp_pc, restart_pc;
  logic [IDX_W-1:0]       disp_tag, fin_tag;
  logic [DEST_W-1:0]      fin_dest;
  logic [DATA_W-1:0]      fin_data;
  logic [NRET-1:0]        ret_en;
  logic [NRET*DEST_W-1:0] ret_dest;
  logic [NRET*DATA_W-1:0] ret_data;

  reorder_buf dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_pc(disp_pc), .disp_tag(disp_tag), .fin_valid(fin_valid), .fin_tag(fin_tag),
    .fin_exc(fin_exc), .fin_dest(fin_dest), .fin_data(fin_data), .ret_en(ret_en),
    .ret_dest(ret_dest), .ret_data(ret_data), .flush(flush), .restart_pc(restart_pc)
  );

  typedef struct packed { logic [DEST_W-1:0] dest; logic [DATA_W-1:0] data; } exp_t;
  exp_t expq[$];
  int checks = 0, fails = 0, retired = 0, dual = 0;
  bit done_flag = 0;
  logic [IDX_W-1:0] t [8];
  logic [IDX_W-1:0] fill [DEPTH];
  logic [IDX_W-1:0] tg;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_exp(input logic [DEST_W-1:0] d, input logic [DATA_W-1:0] v);
    expq.push_back({d, v});
  endtask

  task automatic do_disp(input logic [PC_W-1:0] pc, output logic [IDX_W-1:0] tag);
    disp_valid = 1'b1;
    disp_pc = pc;
    while (!disp_ready) tick();
    tag = disp_tag;
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic do_fin(input logic [IDX_W-1:0] tag, input logic exc,
                        input logic [DEST_W-1:0] d, input logic [DATA_W-1:0] v);
    fin_valid = 1'b1; fin_tag = tag; fin_exc = exc; fin_dest = d; fin_data = v;
    tick();
    fin_valid = 1'b0; fin_exc = 1'b0;
  endtask

  // monitor: pops the scoreboard on every commit lane, oldest lane first
  always @(negedge clk) begin
    if (rst_n) begin
      if (&ret_en) dual++;
      for (int k = 0; k < NRET; k++) begin
        if (ret_en[k]) begin
          exp_t e;
          retired++;
          if (expq.size() == 0) begin
            check(1'b0, "R8", "commit with empty scoreboard (dest)",
                  64'(ret_dest[k*DEST_W +: DEST_W]), 64'h0);
          end else begin
            e = expq.pop_front();
            check(ret_dest[k*DEST_W +: DEST_W] == e.dest && ret_data[k*DATA_W +: DATA_W] == e.data,
                  "R5", "commit {dest,data}",
                  {27'h0, ret_dest[k*DEST_W +: DEST_W], ret_data[k*DATA_W +: DATA_W]},
                  {27'h0, e.dest, e.data});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 64'h0, 64'h1);
    report();
  end

  initial begin
    rst_n = 0; disp_valid = 0; disp_pc = '0; fin_valid = 0; fin_tag = '0;
    fin_exc = 0; fin_dest = '0; fin_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    check(disp_ready == 1'b1, "R1", "disp_ready", 64'(disp_ready), 64'h1);
    check(ret_en == '0, "R1", "ret_en", 64'(ret_en), 64'h0);
    check(flush == 1'b0, "R1", "flush", 64'(flush), 64'h0);
    check(disp_tag == '0, "R1", "disp_tag", 64'(disp_tag), 64'h0);

    // R4/R5: out-of-order finishes, commit held until the head finishes
    for (int k = 0; k < 4; k++) begin
      do_disp(32'h100 + 32'(4*k), t[k]);
      check(t[k] == IDX_W'(k), "R2", "tag sequence", 64'(t[k]), 64'(k));
      push_exp(DEST_W'(k+1), 32'hA0 + 32'(k));
    end
    do_fin(t[3], 1'b0, 5'd4, 32'hA3);
    do_fin(t[1], 1'b0, 5'd2, 32'hA1);
    do_fin(t[2], 1'b0, 5'd3, 32'hA2);
    check(ret_en == '0, "R5", "no commit while head unfinished", 64'(ret_en), 64'h0);
    do_fin(t[0], 1'b0, 5'd1, 32'hA0);
    check(ret_en == 2'b11, "R6", "two lanes first cycle", 64'(ret_en), 64'h3);
    tick();
    check(ret_en == 2'b11, "R6", "two lanes second cycle", 64'(ret_en), 64'h3);
    tick();
    check(ret_en == '0 && disp_tag == 6'd4, "R4", "drained, tag",
          {56'h0, ret_en, disp_tag}, {56'h0, 2'b00, 6'd4});

    // R2/R3: fill to capacity with wrap-around tags
    for (int i = 0; i < DEPTH; i++) begin
      do_disp(32'h1000 + 32'(4*i), tg);
      fill[i] = tg;
      check(tg == IDX_W'((4 + i) % DEPTH), "R2", "wrapping tag", 64'(tg), 64'((4 + i) % DEPTH));
    end
    check(disp_ready == 1'b0, "R3", "ready low when full", 64'(disp_ready), 64'h0);
    disp_valid = 1'b1;
    repeat (3) tick();
    check(disp_ready == 1'b0 && disp_tag == 6'd4, "R3", "full holds tag",
          {57'h0, disp_ready, disp_tag}, {57'h0, 1'b0, 6'd4});
    disp_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) push_exp(DEST_W'((i % 31) + 1), 32'hC000 + 32'(i));
    retired = 0; dual = 0;
    for (int i = DEPTH - 1; i >= 0; i--)
      do_fin(fill[i], 1'b0, DEST_W'((i % 31) + 1), 32'hC000 + 32'(i));
    repeat (22) tick();
    check(retired == DEPTH, "R3", "committed count after full", 64'(retired), 64'(DEPTH));
    check(dual == DEPTH / 2, "R6", "dual-lane cycles", 64'(dual), 64'(DEPTH / 2));
    check(disp_ready == 1'b1, "R3", "ready after drain", 64'(disp_ready), 64'h1);

    // R7/R8/R9: exception in the second entry, younger ones already finished
    for (int k = 0; k < 6; k++) do_disp(32'h2000 + 32'(4*k), t[k]);
    push_exp(5'd9, 32'h55);
    do_fin(t[1], 1'b1, 5'd10, 32'h66);
    for (int k = 2; k < 6; k++) do_fin(t[k], 1'b0, DEST_W'(10 + k), 32'h70 + 32'(k));
    check(ret_en == '0, "R5", "blocked by unfinished head", 64'(ret_en), 64'h0);
    do_fin(t[0], 1'b0, 5'd9, 32'h55);
    check(ret_en == 2'b01, "R7", "only older entry commits", 64'(ret_en), 64'h1);
    check(flush == 1'b0, "R7", "no flush before head reaches fault", 64'(flush), 64'h0);
    tick();
    check(flush == 1'b1, "R8", "flush pulse", 64'(flush), 64'h1);
    check(restart_pc == 32'h2004, "R8", "restart pc", 64'(restart_pc), 64'h2004);
    check(ret_en == '0 && disp_ready == 1'b0, "R8", "quiet during flush",
          {61'h0, ret_en, disp_ready}, 64'h0);
    tick();
    check(flush == 1'b0, "R8", "flush one cycle", 64'(flush), 64'h0);
    check(disp_tag == t[1], "R9", "tail back at fault slot", 64'(disp_tag), 64'(t[1]));
    check(disp_ready == 1'b1, "R9", "ready after flush", 64'(disp_ready), 64'h1);
    do_disp(32'h3000, tg);
    check(tg == t[1], "R9", "reused slot", 64'(tg), 64'(t[1]));
    push_exp(5'd12, 32'h77);
    do_fin(tg, 1'b0, 5'd12, 32'h77);
    repeat (3) tick();
    check(expq.size() == 0, "R9", "scoreboard empty", 64'(expq.size()), 64'h0);
    report();
  end
endmodule